// File: doc/BRIEF.md
# Receive-Queue Watermark Flow Controller

This block decides when the local MAC transmitter must hold back the far-end station. The decision rests on how full the receive queue is. It compares the current fill level, counted in blocks, against a host-programmed high threshold. In full duplex it raises a pause-frame request toward the transmitter. In half duplex it drives a jam level that makes the far end see collisions and slow down. The pause request follows a valid/ready handshake. It carries the programmed pause time in slot quanta and travels with the reserved multicast destination address used for pause frames.

There are two modes. In automatic mode, which is the state after reset, only the high-threshold comparison acts and host control writes are locked out. In manual mode the host raises pauses and jam directly through a control write. The low threshold only feeds a status flag. An invalid queue-size and threshold combination is flagged and blocks automatic action. After a pause has been accepted, the block arms again when the fill falls back to the threshold or below. It also arms again when the transmitter reports the pause frame as sent and the pause period has then run out.

Top module: `wmFlowCtl`

## Requirements
- R1: After reset the block is in automatic mode (`autoActive`=1), `pauseValid` and `jamOut` are 0, and the pause time register holds 80 quanta, so the first automatic pause carries 80.
- R2: `cfgError` is 1 whenever queue size < 2, high threshold = 0, or high threshold >= queue size. While it is 1, automatic mode raises neither a pause nor jam.
- R3: In automatic full-duplex operation with the block armed, a fill strictly greater than the high threshold at a clock edge raises `pauseValid` after that edge. Only one request is raised per crossing. `aboveHigh` shows fill > high threshold without delay.
- R4: While `pauseValid`=1 and `pauseReady`=0, `pauseValid` and `pauseTimer` hold their values. An edge with both at 1 accepts the request, and `pauseValid` reads 0 after that edge.
- R5: After acceptance the block arms again as soon as fill <= high threshold. If the fill stays above the threshold, it arms again once `pauseDone` is seen and then pause time × QUANTUM_CYC cycles have elapsed. The next request follows one edge later.
- R6: In automatic half-duplex operation `jamOut` equals `aboveHigh` in the same cycle, given no config error. `jamOut` is never 1 in full duplex.
- R7: While a host write has its auto bit (`hostAutoEn`) at 1, its pause-trigger, flow-enable and jam-enable bits have no effect.
- R8: A host write with `hostAutoEn`=0 selects manual mode. In half duplex `jamOut` then follows the written jam-enable bit, and in full duplex a write with both pause-trigger and flow-enable at 1 raises `pauseValid` after that edge. The fill level triggers nothing in manual mode.
- R9: `congClear` is 1 exactly when fill <= low threshold. The low threshold affects no pause or jam decision.
- R10: A change of `fullDuplexIn` is adopted (`duplexActive`) at once when no request is pending, and only after acceptance when one is pending. `jamOut` falls in the same cycle that full duplex becomes active.
- R11: `pauseDestAddr` always reads 48'h0180C2000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fillLevel | input | LEVEL_W | Current receive-queue fill in blocks |
| queueSize | input | LEVEL_W | Configured queue size in blocks |
| highThresh | input | LEVEL_W | High watermark |
| lowThresh | input | LEVEL_W | Low watermark (status only) |
| fullDuplexIn | input | 1 | Requested duplex mode, 1 = full |
| hostWr | input | 1 | Host control write strobe |
| hostAutoEn | input | 1 | Write data: automatic mode enable |
| hostPauseTrig | input | 1 | Write data: manual pause trigger |
| hostFcEn | input | 1 | Write data: manual flow-control enable |
| hostJamEn | input | 1 | Write data: manual jam enable |
| hostTimerLoad | input | 1 | Write data: load pause time |
| hostTimerVal | input | TIMER_W | Write data: pause time in quanta |
| pauseReady | input | 1 | Transmitter accepts the pause request |
| pauseDone | input | 1 | Transmitter has sent the pause frame |
| pauseValid | output | 1 | Pause frame request |
| pauseTimer | output | TIMER_W | Pause time carried by the request |
| pauseDestAddr | output | 48 | Pause frame destination address |
| jamOut | output | 1 | Half-duplex jam level |
| aboveHigh | output | 1 | Fill above high watermark |
| congClear | output | 1 | Fill at or below low watermark |
| cfgError | output | 1 | Invalid size/threshold setting |
| autoActive | output | 1 | Automatic mode in effect |
| duplexActive | output | 1 | Duplex mode in effect, 1 = full |

## Verification
Two events can land in the same cycle: a duplex change and a pause request that is still waiting for the transmitter. The bench provokes this by holding `pauseReady` low and moving `fullDuplexIn` to half duplex. It then expects `duplexActive` to stay at full and `jamOut` to stay low until the acceptance edge, and the switch to happen right after that edge. A second collision is the end of the hold-off against a queue that is still above the threshold. The bench judges it by where the repeated request appears, one edge after the counted period. A cycle-level model in the bench predicts every output on every clock.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam logic [47:0] PAUSE_DEST_ADDR = 48'h0180C2000001;
  localparam int DEFAULT_PAUSE_QUANTA = 80;

  typedef enum logic [1:0] {
    ST_ARMED     = 2'd0,
    ST_REQ       = 2'd1,
    ST_WAIT_DONE = 2'd2,
    ST_HOLDOFF   = 2'd3
  } fcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPause;     // capture pause time into the request
    logic startHoldoff;  // load hold-off counter
    logic countDown;     // decrement hold-off counter
    logic pending;       // request outstanding, freeze duplex
  } fcStrobes_t;
endpackage

// File: rtl/fcDatapath.sv
module fcDatapath
  import fc_pkg::*;
#(
  parameter int LEVEL_W     = 8,
  parameter int TIMER_W     = 16,
  parameter int QUANTUM_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] fillLevel,
  input  logic [LEVEL_W-1:0] queueSize,
  input  logic [LEVEL_W-1:0] highThresh,
  input  logic [LEVEL_W-1:0] lowThresh,
  input  logic               fullDuplexIn,
  input  logic               hostWr,
  input  logic               hostAutoEn,
  input  logic               hostJamEn,
  input  logic               hostTimerLoad,
  input  logic [TIMER_W-1:0] hostTimerVal,
  input  fcStrobes_t         strobes,
  output logic               aboveHigh,
  output logic               cfgError,
  output logic               congClear,
  output logic               fdEff,
  output logic               autoMode,
  output logic               holdoffDone,
  output logic [TIMER_W-1:0] heldTimer,
  output logic               jamOut
);
  localparam int CNT_W = TIMER_W + $clog2(QUANTUM_CYC + 1);

  logic               autoReg;
  logic               jamEnReg;
  logic               fdReg;
  logic [TIMER_W-1:0] timerReg;
  logic [CNT_W-1:0]   holdCnt;

  assign aboveHigh = fillLevel > highThresh;
  assign congClear = fillLevel <= lowThresh;
  assign cfgError  = (queueSize < LEVEL_W'(2)) || (highThresh == '0) ||
                     (highThresh >= queueSize);
  assign fdEff     = strobes.pending ? fdReg : fullDuplexIn;
  assign autoMode  = autoReg;
  assign holdoffDone = holdCnt <= CNT_W'(1);
  assign jamOut    = !fdEff && (autoReg ? (aboveHigh && !cfgError) : jamEnReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoReg  <= 1'b1;
      jamEnReg <= 1'b0;
      fdReg    <= 1'b1;
      timerReg <= TIMER_W'(DEFAULT_PAUSE_QUANTA);
    end else begin
      fdReg <= fdEff;
      if (hostWr) begin
        autoReg <= hostAutoEn;
        if (!hostAutoEn) jamEnReg <= hostJamEn;
        if (hostTimerLoad) timerReg <= hostTimerVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldTimer <= '0;
      holdCnt   <= '0;
    end else begin
      if (strobes.loadPause) heldTimer <= timerReg;
      if (strobes.startHoldoff)
        holdCnt <= CNT_W'(heldTimer) * CNT_W'(QUANTUM_CYC);
      else if (strobes.countDown && holdCnt != '0)
        holdCnt <= holdCnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fcControl.sv
module fcControl
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       aboveHigh,
  input  logic       cfgError,
  input  logic       fdEff,
  input  logic       autoMode,
  input  logic       holdoffDone,
  input  logic       hostWr,
  input  logic       hostAutoEn,
  input  logic       hostPauseTrig,
  input  logic       hostFcEn,
  input  logic       pauseReady,
  input  logic       pauseDone,
  output fcStrobes_t strobes,
  output logic       pauseValid
);
  fcState_e state, stateNext;
  logic autoFire, manFire, fire;

  assign autoFire = autoMode && fdEff && aboveHigh && !cfgError && (state == ST_ARMED);
  assign manFire  = hostWr && !hostAutoEn && hostPauseTrig && hostFcEn && fdEff &&
                    (state != ST_REQ);
  assign fire     = autoFire || manFire;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_ARMED:     if (fire) stateNext = ST_REQ;
      ST_REQ:       if (pauseReady) stateNext = ST_WAIT_DONE;
      ST_WAIT_DONE: begin
        if (manFire)         stateNext = ST_REQ;
        else if (!aboveHigh) stateNext = ST_ARMED;
        else if (pauseDone)  stateNext = ST_HOLDOFF;
      end
      ST_HOLDOFF: begin
        if (manFire)          stateNext = ST_REQ;
        else if (!aboveHigh)  stateNext = ST_ARMED;
        else if (holdoffDone) stateNext = ST_ARMED;
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.loadPause    = fire;
    strobes.startHoldoff = (state == ST_WAIT_DONE) && (stateNext == ST_HOLDOFF);
    strobes.countDown    = (state == ST_HOLDOFF);
    strobes.pending      = (state == ST_REQ);
  end

  assign pauseValid = (state == ST_REQ);
endmodule

// File: rtl/wmFlowCtl.sv
module wmFlowCtl
  import fc_pkg::*;
#(
  parameter int LEVEL_W     = 8,
  parameter int TIMER_W     = 16,
  parameter int QUANTUM_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] fillLevel,
  input  logic [LEVEL_W-1:0] queueSize,
  input  logic [LEVEL_W-1:0] highThresh,
  input  logic [LEVEL_W-1:0] lowThresh,
  input  logic               fullDuplexIn,
  input  logic               hostWr,
  input  logic               hostAutoEn,
  input  logic               hostPauseTrig,
  input  logic               hostFcEn,
  input  logic               hostJamEn,
  input  logic               hostTimerLoad,
  input  logic [TIMER_W-1:0] hostTimerVal,
  input  logic               pauseReady,
  input  logic               pauseDone,
  output logic               pauseValid,
  output logic [TIMER_W-1:0] pauseTimer,
  output logic [47:0]        pauseDestAddr,
  output logic               jamOut,
  output logic               aboveHigh,
  output logic               congClear,
  output logic               cfgError,
  output logic               autoActive,
  output logic               duplexActive
);
  fcStrobes_t strobes;
  logic holdoffDone;

  fcDatapath #(.LEVEL_W(LEVEL_W), .TIMER_W(TIMER_W), .QUANTUM_CYC(QUANTUM_CYC)) dpI (
    .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .queueSize(queueSize),
    .highThresh(highThresh), .lowThresh(lowThresh), .fullDuplexIn(fullDuplexIn),
    .hostWr(hostWr), .hostAutoEn(hostAutoEn), .hostJamEn(hostJamEn),
    .hostTimerLoad(hostTimerLoad), .hostTimerVal(hostTimerVal), .strobes(strobes),
    .aboveHigh(aboveHigh), .cfgError(cfgError), .congClear(congClear),
    .fdEff(duplexActive), .autoMode(autoActive), .holdoffDone(holdoffDone),
    .heldTimer(pauseTimer), .jamOut(jamOut)
  );

  fcControl ctlI (
    .clk(clk), .rstN(rstN), .aboveHigh(aboveHigh), .cfgError(cfgError),
    .fdEff(duplexActive), .autoMode(autoActive), .holdoffDone(holdoffDone),
    .hostWr(hostWr), .hostAutoEn(hostAutoEn), .hostPauseTrig(hostPauseTrig),
    .hostFcEn(hostFcEn), .pauseReady(pauseReady), .pauseDone(pauseDone),
    .strobes(strobes), .pauseValid(pauseValid)
  );

  assign pauseDestAddr = PAUSE_DEST_ADDR;
endmodule

// File: rtl/fcChecker.sv
module fcChecker #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               pauseValid,
  input logic               pauseReady,
  input logic [TIMER_W-1:0] pauseTimer,
  input logic               jamOut,
  input logic               cfgError,
  input logic               autoActive,
  input logic               duplexActive
);
  a_r4_request_held: assert property (@(posedge clk) disable iff (!rstN)
    pauseValid && !pauseReady |=> pauseValid && $stable(pauseTimer));

  a_r10_duplex_frozen: assert property (@(posedge clk) disable iff (!rstN)
    pauseValid && !pauseReady |=> $stable(duplexActive));

  a_r6_no_jam_full: assert property (@(posedge clk) disable iff (!rstN)
    duplexActive |-> !jamOut);

  a_r2_err_blocks_jam: assert property (@(posedge clk) disable iff (!rstN)
    cfgError && autoActive |-> !jamOut);

  a_r3_pause_in_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseValid) |-> duplexActive);
endmodule

bind wmFlowCtl fcChecker #(.TIMER_W(TIMER_W)) chkI (
  .clk(clk), .rstN(rstN), .pauseValid(pauseValid), .pauseReady(pauseReady),
  .pauseTimer(pauseTimer), .jamOut(jamOut), .cfgError(cfgError),
  .autoActive(autoActive), .duplexActive(duplexActive)
);

// File: tb/wmFlowCtl_tb_top.sv
`timescale 1ns/1ps
module wmFlowCtl_tb_top;
  localparam int LW = 8, TW = 16, QC = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic [LW-1:0] fillLevel = '0, queueSize = 8'd16, highThresh = 8'd10, lowThresh = 8'd4;
  logic fullDuplexIn = 1'b1, hostWr = 1'b0, hostAutoEn = 1'b1, hostPauseTrig = 1'b0;
  logic hostFcEn = 1'b0, hostJamEn = 1'b0, hostTimerLoad = 1'b0;
  logic [TW-1:0] hostTimerVal = '0;
  logic pauseReady = 1'b0, pauseDone = 1'b0;
  logic pauseValid, jamOut, aboveHigh, congClear, cfgError, autoActive, duplexActive;
  logic [TW-1:0] pauseTimer;
  logic [47:0] pauseDestAddr;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wmFlowCtl #(.LEVEL_W(LW), .TIMER_W(TW), .QUANTUM_CYC(QC)) dut_i (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 armed, 1 request, 2 wait done, 3 hold-off
  int mState = 0, mTimer = 80, mHeld = 0, mCnt = 0;
  bit mAuto = 1, mJamEn = 0, mFdReg = 1;

  function automatic bit fdNow();
    return (mState == 1) ? mFdReg : fullDuplexIn;
  endfunction
  function automatic bit errNow();
    return (queueSize < 2) || (highThresh == 0) || (highThresh >= queueSize);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTimer = 80; mHeld = 0; mCnt = 0; mAuto = 1; mJamEn = 0; mFdReg = 1;
    end else begin
      bit fd, above, autoFire, manFire;
      int ns;
      fd = fdNow();
      above = fillLevel > highThresh;
      autoFire = mAuto && fd && above && !errNow() && mState == 0;
      manFire = hostWr && !hostAutoEn && hostPauseTrig && hostFcEn && fd && mState != 1;
      ns = mState;
      case (mState)
        0: if (autoFire || manFire) ns = 1;
        1: if (pauseReady) ns = 2;
        2: if (manFire) ns = 1;
           else if (!above) ns = 0;
           else if (pauseDone) begin ns = 3; mCnt = mHeld * QC; end
        default: if (manFire) ns = 1;
           else if (!above) ns = 0;
           else if (mCnt <= 1) ns = 0;
           else mCnt--;
      endcase
      if (autoFire || manFire) mHeld = mTimer;
      mFdReg = fd;
      if (hostWr) begin
        mAuto = hostAutoEn;
        if (!hostAutoEn) mJamEn = hostJamEn;
        if (hostTimerLoad) mTimer = int'(hostTimerVal);
      end
      mState = ns;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit fd, above, err;
      fd = fdNow();
      above = fillLevel > highThresh;
      err = errNow();
      chk("R3 pauseValid", pauseValid, mState == 1);
      if (mState == 1) chk("R4 pauseTimer", pauseTimer, mHeld);
      chk("R6 jamOut", jamOut, !fd && (mAuto ? (above && !err) : mJamEn));
      chk("R3 aboveHigh", aboveHigh, above);
      chk("R9 congClear", congClear, fillLevel <= lowThresh);
      chk("R2 cfgError", cfgError, err);
      chk("R1 autoActive", autoActive, mAuto);
      chk("R10 duplexActive", duplexActive, fd);
      chk("R11 pauseDestAddr", pauseDestAddr, 48'h0180C2000001);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hostWrite(bit au, bit trig, bit fc, bit jam);
    hostWr = 1; hostAutoEn = au; hostPauseTrig = trig; hostFcEn = fc; hostJamEn = jam;
    step(1);
    hostWr = 0; hostPauseTrig = 0; hostFcEn = 0; hostJamEn = 0;
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(1);
    // R1 reset state
    chk("R1 autoActive after reset", autoActive, 1);
    chk("R1 pauseValid after reset", pauseValid, 0);
    chk("R1 jamOut after reset", jamOut, 0);
    chk("R11 dest address", pauseDestAddr, 48'h0180C2000001);

    // R3/R4/R1: automatic pause with default time, stalled transmitter
    fillLevel = 12;
    step(1);
    chk("R3 pause raised after crossing", pauseValid, 1);
    step(3);
    chk("R4 still pending while not ready", pauseValid, 1);
    chk("R1 default pause time", pauseTimer, 80);
    pauseReady = 1; step(1); pauseReady = 0;
    chk("R4 released after accept", pauseValid, 0);
    step(5);
    chk("R3 single request per crossing", pauseValid, 0);
    pauseDone = 1; step(1); pauseDone = 0;
    fillLevel = 5; step(2);
    chk("R9 congClear off above low", congClear, 0);
    fillLevel = 3; step(1);
    chk("R9 congClear at low", congClear, 1);
    chk("R9 no pause from low threshold", pauseValid, 0);

    // R5: hold-off timing with pause time 3 -> 24 cycles
    hostWr = 1; hostAutoEn = 1; hostTimerLoad = 1; hostTimerVal = 3;
    step(1);
    hostWr = 0; hostTimerLoad = 0;
    fillLevel = 12; step(1);
    chk("R3 pause after rearm", pauseValid, 1);
    chk("R5 new pause time carried", pauseTimer, 3);
    pauseReady = 1; step(1); pauseReady = 0;
    pauseDone = 1; step(1); pauseDone = 0;
    step(20);
    chk("R5 no repeat during hold-off", pauseValid, 0);
    step(10);
    chk("R5 repeat after hold-off", pauseValid, 1);
    pauseReady = 1; step(1); pauseReady = 0;
    fillLevel = 5; step(2);

    // R6/R10: half-duplex jam, immediate drop on switch to full
    fullDuplexIn = 0; fillLevel = 12; step(1);
    chk("R6 jam while above", jamOut, 1);
    fullDuplexIn = 1; #0.5;
    chk("R10 jam drops same cycle", jamOut, 0);
    step(1);
    pauseReady = 1; step(2); pauseReady = 0;
    fillLevel = 8; fullDuplexIn = 0; step(1);
    chk("R6 jam off at threshold", jamOut, 0);

    // R2: invalid settings block automatic action
    highThresh = 0; fillLevel = 12; step(1);
    chk("R2 err high zero", cfgError, 1);
    chk("R2 no jam on error", jamOut, 0);
    fullDuplexIn = 1; step(3);
    chk("R2 no pause on error", pauseValid, 0);
    highThresh = 16; fillLevel = 20; step(1);
    chk("R2 err high >= size", cfgError, 1);
    queueSize = 1; highThresh = 0; step(1);
    chk("R2 err small size", cfgError, 1);
    queueSize = 16; highThresh = 10; fillLevel = 5; step(2);

    // R7: manual bits ignored in automatic mode
    hostWrite(1, 1, 1, 1);
    step(2);
    chk("R7 trigger ignored", pauseValid, 0);
    fullDuplexIn = 0; step(1);
    chk("R7 jam enable ignored", jamOut, 0);

    // R8: manual mode
    hostWrite(0, 0, 0, 1);
    chk("R8 manual mode", autoActive, 0);
    chk("R8 manual jam below threshold", jamOut, 1);
    fillLevel = 12;
    hostWrite(0, 0, 0, 0);
    chk("R8 manual jam off above threshold", jamOut, 0);
    fullDuplexIn = 1; step(2);
    chk("R8 no automatic pause in manual", pauseValid, 0);
    hostWrite(0, 1, 0, 0);
    chk("R8 trigger without enable", pauseValid, 0);
    hostWrite(0, 1, 1, 0);
    chk("R8 manual pause", pauseValid, 1);

    // R10: duplex change deferred while pending
    fullDuplexIn = 0; step(2);
    chk("R10 duplex held while pending", duplexActive, 1);
    pauseReady = 1; step(1); pauseReady = 0;
    chk("R10 duplex adopted after accept", duplexActive, 0);
    step(2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule